// File: doc/BRIEF.md
# Prime-Modulus Shift Register for a Word Stream Cipher

This block is the state register of a word-oriented stream cipher. It holds sixteen 31-bit cells and does all of its arithmetic modulo the Mersenne prime 2^31-1. A load operation builds the starting state from a 128-bit key, a 128-bit initialization vector and sixteen fixed 15-bit constants. After that, each step shifts the cells down by one position and writes a newly computed word into the top cell.

The new word is a weighted sum of five cells. The weights are powers of two, so each product is a 31-bit rotation, and the terms are added with end-around-carry adders. The block has two modes. In init mode, one more modular adder folds in the upper 31 bits of the 32-bit word that the nonlinear stage returns. In work mode the sum is written back unchanged. All cells are visible on one wide tap bus so that an outside bit-reorganization stage can take its fields from them. A round counter raises a ready flag once the required number of init steps has been taken since the last load. From then on, downstream logic can produce one keystream word per step.

Top module: `mp_lfsr`

## Requirements
- R1: While rst_n is low, every cell is 0 and ready is 0.
- R2: A load makes cell i equal to {key byte i, D_i, iv byte i}, with the key byte in bits 30:23, D_i in bits 22:8 and the iv byte in bits 7:0. Key byte 0 is key[127:120] and byte i is key[127-8i -: 8]; the iv bytes use the same order. Cell i appears on cells[31i+30:31i].
- R3: On a step without load, cell i takes the old value of cell i+1 for i from 0 to 14.
- R4: On a work-mode step (mode=0), the new cell 15 is v = 2^15·s15 + 2^17·s13 + 2^21·s10 + 2^20·s4 + (1+2^8)·s0 mod (2^31-1). Each product is a left rotation of the 31-bit cell.
- R5: On an init-mode step (mode=1), the new cell 15 is (v + w_in[31:1]) mod (2^31-1). Bit 0 of w_in has no effect.
- R6: A new cell-15 value that would be 0 is written as 0x7FFFFFFF.
- R7: ready rises in the cycle after the 32nd init-mode step that follows a load, and not earlier. Work-mode steps do not count.
- R8: A load clears ready. Once ready is set, further init steps leave it set until the next load.
- R9: With neither load nor step asserted, every cell holds its value.
- R10: When load and step are both asserted, load wins and the step is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| load | input | 1 | Build the state from key and iv |
| key | input | 128 | Secret key |
| iv | input | 128 | Initialization vector |
| step | input | 1 | Advance the register by one position |
| mode | input | 1 | 1 = init (fold in w_in), 0 = work |
| w_in | input | 32 | Output of the nonlinear stage; bits 31:1 are used |
| cells | output | 496 | All cells; cell i at bits 31i+30:31i |
| ready | output | 1 | Required init steps completed since the last load |

## Verification
The bench starts stepping from the all-zero reset state, which is the only case where the weighted sum comes out as zero. An init step with w_in equal to 1 adds nothing, so together these cases catch a design that writes a zero cell instead of 0x7FFFFFFF. It feeds odd and even w_in words, so a design that folds in bit 0, or the low 31 bits instead of the upper 31, gives a different top cell. It samples ready after every one of the 32 init steps, and again after work steps taken following a reload. This catches an off-by-one terminal count, a counter that also counts work steps, and a flag that survives a reload. It also asserts load and step together to confirm that the load wins.

// File: rtl/mlfsr_pkg.sv
package mlfsr_pkg;
  localparam int CELL_W = 31;
  localparam int NCELLS = 16;
  localparam int BYTE_W = 8;
  localparam int DC_W   = 15;
  localparam int NTAPS  = 6;

  typedef logic [CELL_W-1:0] cell_t;
  typedef logic [NCELLS-1:0][CELL_W-1:0] bank_t;

  typedef enum logic {
    MODE_WORK = 1'b0,
    MODE_INIT = 1'b1
  } mode_e;

  // which cell feeds weighted term t
  function automatic int tap_cell(int t);
    case (t)
      0, 1:    tap_cell = 0;
      2:       tap_cell = 4;
      3:       tap_cell = 10;
      4:       tap_cell = 13;
      default: tap_cell = 15;
    endcase
  endfunction

  // rotation amount (power-of-two weight) of term t
  function automatic int tap_rot(int t);
    case (t)
      0:       tap_rot = 0;
      1:       tap_rot = 8;
      2:       tap_rot = 20;
      3:       tap_rot = 21;
      4:       tap_rot = 17;
      default: tap_rot = 15;
    endcase
  endfunction

  // multiply by 2^k modulo 2^31-1
  function automatic cell_t rotl(cell_t x, int k);
    rotl = (x << k) | (x >> (CELL_W - k));
  endfunction
endpackage

// File: rtl/mp_add.sv
module mp_add
  import mlfsr_pkg::*;
(
  input  cell_t a,
  input  cell_t b,
  output cell_t y
);
  logic [CELL_W:0] raw;

  always_comb begin
    raw = {1'b0, a} + {1'b0, b};
    y   = raw[CELL_W-1:0] + cell_t'(raw[CELL_W]);
  end

  // end-around carry yields zero only when both operands are zero (R4)
  always_comb begin
    p_add_zero_only_r4: assert (y != '0 || (a == '0 && b == '0));
  end
endmodule

// File: rtl/mp_keyload.sv
module mp_keyload
  import mlfsr_pkg::*;
#(
  parameter logic [DC_W-1:0] DCONST [NCELLS] = '{
    15'h44D7, 15'h26BC, 15'h626B, 15'h135E, 15'h5789, 15'h35E2, 15'h7135, 15'h09AF,
    15'h4D78, 15'h2F13, 15'h6BC4, 15'h1AF1, 15'h5E26, 15'h3C4D, 15'h789A, 15'h47AC}
)(
  input  logic [NCELLS*BYTE_W-1:0] key,
  input  logic [NCELLS*BYTE_W-1:0] iv,
  output bank_t                    init_bank
);
  localparam int KW = NCELLS * BYTE_W;

  for (genvar i = 0; i < NCELLS; i++) begin : g_cell
    assign init_bank[i] = {key[KW-1-i*BYTE_W -: BYTE_W],
                           DCONST[i],
                           iv[KW-1-i*BYTE_W -: BYTE_W]};
  end
endmodule

// File: rtl/mp_feedback.sv
module mp_feedback
  import mlfsr_pkg::*;
(
  input  bank_t bank,
  input  mode_e mode,
  input  cell_t inject,
  output cell_t new_top
);
  cell_t term [NTAPS];
  cell_t acc  [NTAPS];
  cell_t folded;
  cell_t chosen;

  for (genvar t = 0; t < NTAPS; t++) begin : g_term
    assign term[t] = rotl(bank[tap_cell(t)], tap_rot(t));
  end

  assign acc[0] = term[0];
  for (genvar t = 1; t < NTAPS; t++) begin : g_chain
    mp_add u_add (.a(acc[t-1]), .b(term[t]), .y(acc[t]));
  end

  mp_add u_inject (.a(acc[NTAPS-1]), .b(inject), .y(folded));

  always_comb begin
    chosen  = (mode == MODE_INIT) ? folded : acc[NTAPS-1];
    new_top = (chosen == '0) ? '1 : chosen;
  end
endmodule

// File: rtl/mp_round_ctr.sv
module mp_round_ctr #(
  parameter int ROUNDS = 32
)(
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic init_step,
  output logic ready
);
  localparam int CNT_W = $clog2(ROUNDS + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load | (init_step & ~ready);
    cnt_d  = load ? '0 : cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign ready = (cnt_q == CNT_W'(ROUNDS));

  p_ready_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !ready);
  p_ready_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !load) |=> ready);
  p_ready_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> $past(init_step));
endmodule

// File: rtl/mp_lfsr.sv
module mp_lfsr
  import mlfsr_pkg::*;
#(
  parameter int INIT_ROUNDS = 32
)(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     load,
  input  logic [127:0]             key,
  input  logic [127:0]             iv,
  input  logic                     step,
  input  logic                     mode,
  input  logic [31:0]              w_in,
  output logic [NCELLS*CELL_W-1:0] cells,
  output logic                     ready
);
  bank_t bank_q, bank_d, load_bank;
  cell_t new_top;
  mode_e mode_sel;
  logic  bank_en;
  logic  init_step;
  logic  unused_w0;

  assign mode_sel  = mode_e'(mode);
  assign unused_w0 = w_in[0];
  assign init_step = step & ~load & (mode_sel == MODE_INIT);

  mp_keyload u_keyload (.key(key), .iv(iv), .init_bank(load_bank));

  mp_feedback u_fb (
    .bank   (bank_q),
    .mode   (mode_sel),
    .inject (w_in[CELL_W:1]),
    .new_top(new_top)
  );

  mp_round_ctr #(.ROUNDS(INIT_ROUNDS)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .init_step(init_step),
    .ready    (ready)
  );

  always_comb begin
    bank_en = load | step;
    bank_d  = bank_q;
    if (load) begin
      bank_d = load_bank;
    end else if (step) begin
      for (int i = 0; i < NCELLS-1; i++) bank_d[i] = bank_q[i+1];
      bank_d[NCELLS-1] = new_top;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       bank_q <= '0;
    else if (bank_en) bank_q <= bank_d;
  end

  assign cells = bank_q;

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !step) |=> $stable(cells));
  p_shift_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> cells[(NCELLS-1)*CELL_W-1:0] == $past(cells[NCELLS*CELL_W-1:CELL_W]));
  p_top_nonzero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> cells[NCELLS*CELL_W-1 -: CELL_W] != '0);
  p_load_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (load && step) |=> !ready);
endmodule

// File: tb/tb_mp_lfsr.sv
`timescale 1ns/1ps
module tb_mp_lfsr;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         load, step, mode;
  logic [127:0] key, iv;
  logic [31:0]  w_in;
  logic [495:0] cells;
  logic         ready;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  mp_lfsr dut (
    .clk(clk), .rst_n(rst_n), .load(load), .key(key), .iv(iv),
    .step(step), .mode(mode), .w_in(w_in), .cells(cells), .ready(ready)
  );

  localparam logic [14:0] DC [16] = '{
    15'h44D7, 15'h26BC, 15'h626B, 15'h135E, 15'h5789, 15'h35E2, 15'h7135, 15'h09AF,
    15'h4D78, 15'h2F13, 15'h6BC4, 15'h1AF1, 15'h5E26, 15'h3C4D, 15'h789A, 15'h47AC};

  logic [30:0] m [16];
  int          rounds = 0;

  logic [495:0] q_cells [$];
  logic         q_rdy   [$];
  string        q_tag   [$];

  function automatic logic [30:0] madd(logic [30:0] a, logic [30:0] b);
    logic [31:0] s;
    s = {1'b0, a} + {1'b0, b};
    if (s >= 32'h7FFF_FFFF) s = s - 32'h7FFF_FFFF;
    if (s == 0 && (a != 0 || b != 0)) s = 32'h7FFF_FFFF;
    return s[30:0];
  endfunction

  function automatic logic [30:0] mul2k(logic [30:0] x, int k);
    logic [61:0] w;
    w = {31'b0, x} << k;
    return madd(w[30:0], w[61:31]);
  endfunction

  function automatic logic [495:0] flat();
    logic [495:0] f;
    for (int i = 0; i < 16; i++) f[31*i +: 31] = m[i];
    return f;
  endfunction

  task automatic drive(input logic ld, input logic st, input logic md,
                       input logic [127:0] k, input logic [127:0] v,
                       input logic [31:0] w, input string tag);
    logic [30:0] nv;
    @(negedge clk);
    load = ld; step = st; mode = md; key = k; iv = v; w_in = w;
    if (ld) begin
      for (int i = 0; i < 16; i++)
        m[i] = {k[127-8*i -: 8], DC[i], v[127-8*i -: 8]};
      rounds = 0;
    end else if (st) begin
      nv = madd(mul2k(m[15], 15), mul2k(m[13], 17));
      nv = madd(nv, mul2k(m[10], 21));
      nv = madd(nv, mul2k(m[4], 20));
      nv = madd(nv, madd(m[0], mul2k(m[0], 8)));
      if (md) nv = madd(nv, w[31:1]);
      if (nv == 0) nv = 31'h7FFF_FFFF;
      for (int i = 0; i < 15; i++) m[i] = m[i+1];
      m[15] = nv;
      if (md && rounds < 32) rounds++;
    end
    q_cells.push_back(flat());
    q_rdy.push_back(rounds == 32);
    q_tag.push_back(tag);
  endtask

  // monitor: compares each result one cycle after its stimulus
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q_cells.size() > 0) begin
        logic [495:0] ec;
        logic         er;
        string        t;
        ec = q_cells.pop_front();
        er = q_rdy.pop_front();
        t  = q_tag.pop_front();
        checks++;
        if (cells !== ec) begin
          errors++;
          $display("FAIL %s cells actual=%h expected=%h", t, cells, ec);
        end
        checks++;
        if (ready !== er) begin
          errors++;
          $display("FAIL %s ready actual=%b expected=%b", t, ready, er);
        end
      end
    end
  end

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  localparam logic [127:0] K1 = 128'h0123456789ABCDEF_FEDCBA9876543210;
  localparam logic [127:0] V1 = 128'h00112233445566778899AABBCCDDEEFF;

  initial begin
    rst_n = 1'b0; load = 0; step = 0; mode = 0; key = '0; iv = '0; w_in = '0;
    for (int i = 0; i < 16; i++) m[i] = '0;
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (cells !== '0 || ready !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset actual=%h/%b expected=0/0", cells, ready);
    end
    @(negedge clk);
    rst_n = 1'b1;

    drive(0, 1, 0, '0, '0, 32'hFFFF_FFFF, "R6 zero sum in work mode");
    drive(0, 1, 1, '0, '0, 32'h0000_0001, "R5 R3 init step with only bit0 set");
    drive(0, 0, 0, K1, V1, 32'h1234_5678, "R9 idle hold");
    drive(1, 1, 1, K1, V1, 32'hDEAD_BEEF, "R10 R2 load with step");
    drive(0, 0, 1, '0, '0, 32'hFFFF_FFFF, "R9 hold after load");
    for (int r = 0; r < 32; r++)
      drive(0, 1, 1, '0, '0, 32'h9E37_79B9 * (r + 1) + r, "R7 R5 init round");
    drive(0, 1, 1, '0, '0, 32'h8000_0001, "R8 ready stays after extra init step");
    for (int r = 0; r < 20; r++)
      drive(0, 1, 0, '0, '0, 32'hA5A5_A5A5, "R4 R3 work step");
    drive(1, 0, 0, '1, '0, '0, "R8 R2 reload clears ready");
    for (int r = 0; r < 10; r++)
      drive(0, 1, 0, '0, '0, '0, "R7 work steps do not count");
    for (int r = 0; r < 31; r++)
      drive(0, 1, 1, '0, '0, 32'h0F0F_0F0E + r, "R7 ready low before 32");
    drive(0, 1, 1, '0, '0, 32'h0000_0003, "R7 ready at 32");
    drive(0, 0, 0, '0, '0, '0, "R9 final hold");
    repeat (4) @(posedge clk);
    #1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule